// File: doc/BRIEF.md
# Register-Pair Load/Store Address Unit

This unit carries out the memory-access part of an instruction stream. Every address sits in a pair of neighbouring general registers. The pair with index n joins register 2n+1, the upper half, with register 2n, the lower half, into one 64-bit value. A decoded operation arrives with a valid/ready handshake. It carries the kind of access, the pair index, a data register, a signed step, an addressing mode and an immediate. The unit tells the register file which three registers it wants and reads them combinationally in the cycle the operation is accepted. It then forms the effective address and makes one read or one write on a simple valid/ready memory bus.

Each access can move its pair by the step. In post-step mode the move comes after the access, and in pre-step mode it comes before it. Once the bus handshake finishes, the unit raises one-cycle writeback strobes. One strobe returns load data to a register. Two more update the halves of the stepped pair. Immediate loads never touch memory: their value goes to the register writeback one cycle after acceptance. The unit handles one operation at a time and does not detect hazards. Whoever issues the operations keeps any dependent operation back until the writebacks have landed.

Top module: `pairmem_unit`

## Requirements
- R1: For the accepted operation, the register read indices are 2p (lower half) and 2p+1 (upper half) for pair index p, and the data register index is passed through unchanged. A pair writeback targets the same pair index p.
- R2: Mode 0 (plain) and mode 3 both address memory with the low address bits of the current 64-bit pair value, and the pair is never written back.
- R3: Mode 1 (post-step) addresses memory with the old pair value, then writes back the old value plus the step.
- R4: Mode 2 (pre-step) writes back the old value plus the step and addresses memory with that new value.
- R5: The step is signed two's complement and is sign-extended to 64 bits. The pair sum wraps modulo 2^64, and carries and borrows cross from the lower register into the upper one.
- R6: Kind 0 (load) reads memory at the effective address (write enable 0). In the cycle after the read handshake, it raises the register writeback with the data register index and the data that was read.
- R7: Kind 1 stores the data register's value, kind 2 stores the 12-bit immediate sign-extended to 32 bits, and kind 3 stores the full 32-bit immediate. All three assert the write enable and accept all three addressing modes.
- R8: Kind 4 writes the sign-extended 12-bit immediate, and kind 5 the full 32-bit immediate, to the data register. Both do this in the cycle after acceptance and make no memory request.
- R9: While a memory request waits for ready, its address, write enable and write data hold steady, the operation input reports not ready, and no writeback strobe is raised. Pair writeback appears only in the cycle after the handshake.
- R10: When a load's data register is one half of the pair it steps, that half's pair writeback is suppressed and the loaded data is written to it instead. The other half is still updated.
- R11: After reset the unit is ready, with no memory request and no writeback strobe. Kinds 6 and 7 are accepted and cause neither a memory request nor any writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_kind | input | 3 | Operation kind code (see R6 to R8, R11) |
| op_pair | input | 4 | Address pair index |
| op_reg | input | 5 | Data register index (load target or store source) |
| op_step | input | 8 | Signed step |
| op_mode | input | 2 | Addressing mode code (see R2 to R4) |
| op_imm | input | 32 | Immediate; low 12 bits form the short immediate |
| rf_lo_idx | output | 5 | Read index of the pair's lower register |
| rf_hi_idx | output | 5 | Read index of the pair's upper register |
| rf_src_idx | output | 5 | Read index of the data register |
| rf_lo_data | input | 32 | Lower pair register value |
| rf_hi_data | input | 32 | Upper pair register value |
| rf_src_data | input | 32 | Data register value |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| wb_rd_en | output | 1 | Register writeback strobe |
| wb_rd_idx | output | 5 | Register writeback index |
| wb_rd_data | output | 32 | Register writeback data |
| wb_pair_lo_en | output | 1 | Lower pair half writeback strobe |
| wb_pair_hi_en | output | 1 | Upper pair half writeback strobe |
| wb_pair_idx | output | 4 | Pair index being written back |
| wb_pair_lo_data | output | 32 | New lower half |
| wb_pair_hi_data | output | 32 | New upper half |

## Verification
The hardest case to reach is a stepped load whose target register is one half of its own address pair while the bus holds the request stalled. Here the suppression of one pair half, the load writeback and the stall hold must all line up in a single writeback cycle. Directed operations load the lower half and then the upper half of a pair in post-step and pre-step mode while the bench's memory responder adds wait cycles. A random phase then biases a quarter of its loads toward registers inside the chosen pair and varies the responder latency. Directed pair values just below 2^32 and 2^64 drive the carry and wrap paths.

// File: rtl/pairmem_pkg.sv
`timescale 1ns/1ps
package pairmem_pkg;

  typedef enum logic [2:0] {
    K_LD   = 3'd0,
    K_ST   = 3'd1,
    K_STI  = 3'd2,
    K_STIL = 3'd3,
    K_LDI  = 3'd4,
    K_LDIL = 3'd5,
    K_RSV6 = 3'd6,
    K_RSV7 = 3'd7
  } mkind_e;

  typedef enum logic [1:0] {
    M_PLAIN = 2'd0,
    M_POST  = 2'd1,
    M_PRE   = 2'd2,
    M_ALT   = 2'd3
  } amode_e;

  typedef enum logic {
    S_IDLE   = 1'b0,
    S_ACCESS = 1'b1
  } ustate_e;

endpackage

// File: rtl/pairmem_agen.sv
`timescale 1ns/1ps
// Effective address and stepped pair value, purely combinational.
module pairmem_agen
  import pairmem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int STEP_W = 8,
  localparam int PAIR_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] pair_lo,
  input  logic [DATA_W-1:0] pair_hi,
  input  logic [STEP_W-1:0] step,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] next_lo,
  output logic [DATA_W-1:0] next_hi,
  output logic              stepping
);

  logic [PAIR_W-1:0] cur;
  logic [PAIR_W-1:0] delta;
  logic [PAIR_W-1:0] moved;
  amode_e            am;

  always_comb begin
    am       = amode_e'(mode);
    cur      = {pair_hi, pair_lo};
    delta    = {{(PAIR_W-STEP_W){step[STEP_W-1]}}, step};
    moved    = cur + delta;
    stepping = (am == M_POST) || (am == M_PRE);
    eff_addr = (am == M_PRE) ? moved[ADDR_W-1:0] : cur[ADDR_W-1:0];
    next_lo  = moved[DATA_W-1:0];
    next_hi  = moved[PAIR_W-1:DATA_W];
  end

endmodule

// File: rtl/pairmem_dsel.sv
`timescale 1ns/1ps
// Store data and immediate-load data selection.
module pairmem_dsel
  import pairmem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIMM_W = 12
) (
  input  logic [2:0]        kind,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] store_data,
  output logic [DATA_W-1:0] load_imm
);

  logic [DATA_W-1:0] short_x;

  generate
    if (SIMM_W >= DATA_W) begin : g_full
      assign short_x = imm;
    end else begin : g_sext
      assign short_x = {{(DATA_W-SIMM_W){imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
    end
  endgenerate

  always_comb begin
    case (mkind_e'(kind))
      K_ST:    store_data = src;
      K_STI:   store_data = short_x;
      default: store_data = imm;
    endcase
    load_imm = (mkind_e'(kind) == K_LDI) ? short_x : imm;
  end

endmodule

// File: rtl/pairmem_wbsel.sv
`timescale 1ns/1ps
// Per-half pair writeback enables; a load into its own pair keeps its data.
module pairmem_wbsel #(
  parameter int PIDX_W = 4,
  localparam int RIDX_W = PIDX_W + 1
) (
  input  logic              is_load,
  input  logic              stepping,
  input  logic [RIDX_W-1:0] rd,
  input  logic [PIDX_W-1:0] pair,
  output logic              lo_en,
  output logic              hi_en
);

  logic own_pair;

  always_comb begin
    own_pair = is_load && (rd[RIDX_W-1:1] == pair);
    lo_en    = stepping && !(own_pair && !rd[0]);
    hi_en    = stepping && !(own_pair &&  rd[0]);
  end

endmodule

// File: rtl/pairmem_unit.sv
`timescale 1ns/1ps
module pairmem_unit
  import pairmem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int STEP_W = 8,
  parameter int SIMM_W = 12,
  parameter int NPAIR  = 16,
  localparam int PIDX_W = $clog2(NPAIR),
  localparam int RIDX_W = PIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_kind,
  input  logic [PIDX_W-1:0] op_pair,
  input  logic [RIDX_W-1:0] op_reg,
  input  logic [STEP_W-1:0] op_step,
  input  logic [1:0]        op_mode,
  input  logic [DATA_W-1:0] op_imm,
  output logic [RIDX_W-1:0] rf_lo_idx,
  output logic [RIDX_W-1:0] rf_hi_idx,
  output logic [RIDX_W-1:0] rf_src_idx,
  input  logic [DATA_W-1:0] rf_lo_data,
  input  logic [DATA_W-1:0] rf_hi_data,
  input  logic [DATA_W-1:0] rf_src_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wb_rd_en,
  output logic [RIDX_W-1:0] wb_rd_idx,
  output logic [DATA_W-1:0] wb_rd_data,
  output logic              wb_pair_lo_en,
  output logic              wb_pair_hi_en,
  output logic [PIDX_W-1:0] wb_pair_idx,
  output logic [DATA_W-1:0] wb_pair_lo_data,
  output logic [DATA_W-1:0] wb_pair_hi_data
);

  // decode of the offered operation
  mkind_e            kind;
  logic              accept;
  logic              is_mem;
  logic              is_imm;
  logic              is_load;

  // combinational results for the offered operation
  logic [ADDR_W-1:0] ag_addr;
  logic [DATA_W-1:0] ag_lo;
  logic [DATA_W-1:0] ag_hi;
  logic              ag_step;
  logic [DATA_W-1:0] st_data;
  logic [DATA_W-1:0] li_data;
  logic              sel_lo;
  logic              sel_hi;

  // control state
  ustate_e           state_q, state_d;
  logic              hs;
  logic              req_cap;
  logic              rd_cap;

  // request registers (datapath, no reset)
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] nlo_q;
  logic [DATA_W-1:0] nhi_q;
  logic [PIDX_W-1:0] pair_q;
  logic [RIDX_W-1:0] rd_q;
  logic              we_q;
  logic              ld_q;
  logic              loen_q;
  logic              hien_q;

  // writeback registers
  logic              rd_en_q, rd_en_d;
  logic              lo_en_q, lo_en_d;
  logic              hi_en_q, hi_en_d;
  logic [RIDX_W-1:0] rd_idx_q, rd_idx_d;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;

  assign rf_lo_idx  = {op_pair, 1'b0};
  assign rf_hi_idx  = {op_pair, 1'b1};
  assign rf_src_idx = op_reg;

  always_comb begin
    kind    = mkind_e'(op_kind);
    is_mem  = kind inside {K_LD, K_ST, K_STI, K_STIL};
    is_imm  = kind inside {K_LDI, K_LDIL};
    is_load = (kind == K_LD);
    accept  = op_valid && op_ready;
  end

  pairmem_agen #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .STEP_W (STEP_W)
  ) u_agen (
    .pair_lo  (rf_lo_data),
    .pair_hi  (rf_hi_data),
    .step     (op_step),
    .mode     (op_mode),
    .eff_addr (ag_addr),
    .next_lo  (ag_lo),
    .next_hi  (ag_hi),
    .stepping (ag_step)
  );

  pairmem_dsel #(
    .DATA_W (DATA_W),
    .SIMM_W (SIMM_W)
  ) u_dsel (
    .kind       (op_kind),
    .src        (rf_src_data),
    .imm        (op_imm),
    .store_data (st_data),
    .load_imm   (li_data)
  );

  pairmem_wbsel #(
    .PIDX_W (PIDX_W)
  ) u_wbsel (
    .is_load  (is_load),
    .stepping (ag_step),
    .rd       (op_reg),
    .pair     (op_pair),
    .lo_en    (sel_lo),
    .hi_en    (sel_hi)
  );

  // next-state and writeback logic
  always_comb begin
    hs      = (state_q == S_ACCESS) && mem_ready;
    req_cap = accept && is_mem;
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (req_cap) state_d = S_ACCESS;
      S_ACCESS: if (mem_ready) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
    rd_en_d   = (accept && is_imm) || (hs && ld_q);
    lo_en_d   = hs && loen_q;
    hi_en_d   = hs && hien_q;
    rd_cap    = (accept && is_imm) || hs;
    rd_data_d = hs ? mem_rdata : li_data;
    rd_idx_d  = hs ? rd_q : op_reg;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rd_en_q <= 1'b0;
      lo_en_q <= 1'b0;
      hi_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_en_q <= rd_en_d;
      lo_en_q <= lo_en_d;
      hi_en_q <= hi_en_d;
    end
  end

  // request registers, loaded on acceptance of a memory operation
  always_ff @(posedge clk) begin
    if (req_cap) begin
      addr_q  <= ag_addr;
      wdata_q <= st_data;
      nlo_q   <= ag_lo;
      nhi_q   <= ag_hi;
      pair_q  <= op_pair;
      rd_q    <= op_reg;
      we_q    <= !is_load;
      ld_q    <= is_load;
      loen_q  <= sel_lo;
      hien_q  <= sel_hi;
    end
  end

  // register writeback data
  always_ff @(posedge clk) begin
    if (rd_cap) begin
      rd_data_q <= rd_data_d;
      rd_idx_q  <= rd_idx_d;
    end
  end

  assign op_ready        = (state_q == S_IDLE);
  assign mem_valid       = (state_q == S_ACCESS);
  assign mem_we          = we_q;
  assign mem_addr        = addr_q;
  assign mem_wdata       = wdata_q;
  assign wb_rd_en        = rd_en_q;
  assign wb_rd_idx       = rd_idx_q;
  assign wb_rd_data      = rd_data_q;
  assign wb_pair_lo_en   = lo_en_q;
  assign wb_pair_hi_en   = hi_en_q;
  assign wb_pair_idx     = pair_q;
  assign wb_pair_lo_data = nlo_q;
  assign wb_pair_hi_data = nhi_q;

endmodule

// File: rtl/pairmem_chk.sv
`timescale 1ns/1ps
module pairmem_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PIDX_W = 4,
  localparam int RIDX_W = PIDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [2:0]        op_kind,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              wb_rd_en,
  input logic [RIDX_W-1:0] wb_rd_idx,
  input logic              wb_pair_lo_en,
  input logic              wb_pair_hi_en,
  input logic [PIDX_W-1:0] wb_pair_idx
);

  // R9: a pending request blocks new operations
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !op_ready);

  // R9: a stalled request holds still
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9: pair writeback only right after a handshake
  a_r9_pair_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_pair_lo_en || wb_pair_hi_en) |-> $past(mem_valid && mem_ready));

  // R10: load data owns its register over the pair step
  a_r10_lo_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_rd_en && wb_pair_lo_en) |-> (wb_rd_idx != {wb_pair_idx, 1'b0}));

  a_r10_hi_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_rd_en && wb_pair_hi_en) |-> (wb_rd_idx != {wb_pair_idx, 1'b1}));

  // R8: immediate loads never start a memory request
  a_r8_imm_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_kind == 3'd4 || op_kind == 3'd5)) |=> !mem_valid);

  // R6: a read handshake is followed by a register writeback
  a_r6_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> wb_rd_en);

endmodule

bind pairmem_unit pairmem_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .PIDX_W (PIDX_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .op_kind       (op_kind),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .wb_rd_en      (wb_rd_en),
  .wb_rd_idx     (wb_rd_idx),
  .wb_pair_lo_en (wb_pair_lo_en),
  .wb_pair_hi_en (wb_pair_hi_en),
  .wb_pair_idx   (wb_pair_idx)
);

// File: tb/sim_pairmem_unit.sv
`timescale 1ns/1ps
module sim_pairmem_unit;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [2:0]  op_kind;
  logic [3:0]  op_pair;
  logic [4:0]  op_reg;
  logic [7:0]  op_step;
  logic [1:0]  op_mode;
  logic [31:0] op_imm;
  logic [4:0]  rf_lo_idx, rf_hi_idx, rf_src_idx;
  logic [31:0] rf_lo_data, rf_hi_data, rf_src_data;
  logic        mem_valid, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        wb_rd_en, wb_pair_lo_en, wb_pair_hi_en;
  logic [4:0]  wb_rd_idx;
  logic [3:0]  wb_pair_idx;
  logic [31:0] wb_rd_data, wb_pair_lo_data, wb_pair_hi_data;

  pairmem_unit u0 (
    .clk (clk), .rst_n (rst_n),
    .op_valid (op_valid), .op_ready (op_ready), .op_kind (op_kind),
    .op_pair (op_pair), .op_reg (op_reg), .op_step (op_step),
    .op_mode (op_mode), .op_imm (op_imm),
    .rf_lo_idx (rf_lo_idx), .rf_hi_idx (rf_hi_idx), .rf_src_idx (rf_src_idx),
    .rf_lo_data (rf_lo_data), .rf_hi_data (rf_hi_data), .rf_src_data (rf_src_data),
    .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .wb_rd_en (wb_rd_en), .wb_rd_idx (wb_rd_idx), .wb_rd_data (wb_rd_data),
    .wb_pair_lo_en (wb_pair_lo_en), .wb_pair_hi_en (wb_pair_hi_en),
    .wb_pair_idx (wb_pair_idx), .wb_pair_lo_data (wb_pair_lo_data),
    .wb_pair_hi_data (wb_pair_hi_data)
  );

  // behavioural register file and memory, written only by the monitor
  logic [31:0] rf [32];
  logic [31:0] mem [bit [31:0]];

  function automatic logic [31:0] mread(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_C3C3;
  endfunction

  assign rf_lo_data  = rf[rf_lo_idx];
  assign rf_hi_data  = rf[rf_hi_idx];
  assign rf_src_data = rf[rf_src_idx];

  int n_chk = 0;
  int n_fail = 0;
  int acc_cnt = 0;
  int lat = 0;
  bit wd = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expectation state of the reference model
  bit          mem_pend, wb_pend, first;
  logic [31:0] e_addr, e_wdata;
  bit          e_we, e_ld, e_loen, e_hien;
  logic [4:0]  e_rd;
  logic [3:0]  e_pair;
  logic [31:0] e_lo, e_hi;
  string       e_tag;
  bit          x_rden, x_loen, x_hien;
  logic [4:0]  x_rdidx;
  logic [31:0] x_rddata, x_lo, x_hi;
  logic [3:0]  x_pair;
  string       x_tag;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0111;
      mem_pend = 1'b0;
      wb_pend  = 1'b0;
      first    = 1'b1;
    end else begin
      if (first) begin
        chk(op_ready && !mem_valid && !wb_rd_en && !wb_pair_lo_en && !wb_pair_hi_en,
            "R11 reset state", {59'd0, op_ready, mem_valid, wb_rd_en, wb_pair_lo_en, wb_pair_hi_en},
            64'h10);
        first = 1'b0;
      end
      // writeback comparison
      if (wb_pend) begin
        chk(wb_rd_en == x_rden, {x_tag, " rd strobe"}, 64'(wb_rd_en), 64'(x_rden));
        if (x_rden && wb_rd_en) begin
          chk(wb_rd_idx == x_rdidx, {x_tag, " rd index"}, 64'(wb_rd_idx), 64'(x_rdidx));
          chk(wb_rd_data == x_rddata, {x_tag, " rd data"}, 64'(wb_rd_data), 64'(x_rddata));
        end
        chk(wb_pair_lo_en == x_loen, {x_tag, " R10 lo strobe"}, 64'(wb_pair_lo_en), 64'(x_loen));
        chk(wb_pair_hi_en == x_hien, {x_tag, " R10 hi strobe"}, 64'(wb_pair_hi_en), 64'(x_hien));
        if (x_loen || x_hien) begin
          chk(wb_pair_idx == x_pair, "R1 pair writeback index", 64'(wb_pair_idx), 64'(x_pair));
          if (x_loen)
            chk(wb_pair_lo_data == x_lo, {x_tag, " R5 lo sum"}, 64'(wb_pair_lo_data), 64'(x_lo));
          if (x_hien)
            chk(wb_pair_hi_data == x_hi, {x_tag, " R5 hi sum"}, 64'(wb_pair_hi_data), 64'(x_hi));
        end
        if (x_loen) rf[{x_pair, 1'b0}] = x_lo;
        if (x_hien) rf[{x_pair, 1'b1}] = x_hi;
        if (x_rden) rf[x_rdidx] = x_rddata;
        wb_pend = 1'b0;
      end else begin
        chk(!wb_rd_en && !wb_pair_lo_en && !wb_pair_hi_en, "R9 R11 no writeback",
            {61'd0, wb_rd_en, wb_pair_lo_en, wb_pair_hi_en}, 64'd0);
      end
      // memory request comparison
      if (mem_valid) begin
        chk(mem_pend, "R8 R11 unexpected access", 64'(mem_valid), 64'd0);
        chk(!op_ready, "R9 ready while busy", 64'(op_ready), 64'd0);
        chk(mem_addr == e_addr, {e_tag, " address"}, 64'(mem_addr), 64'(e_addr));
        chk(mem_we == e_we, {e_tag, " write enable"}, 64'(mem_we), 64'(e_we));
        if (e_we)
          chk(mem_wdata == e_wdata, {e_tag, " R7 store data"}, 64'(mem_wdata), 64'(e_wdata));
        if (mem_ready && mem_pend) begin
          x_rddata = 32'd0;
          if (e_we) mem[e_addr] = e_wdata;
          else      x_rddata = mread(e_addr);
          x_rden  = e_ld;
          x_rdidx = e_rd;
          x_loen  = e_loen;
          x_hien  = e_hien;
          x_lo    = e_lo;
          x_hi    = e_hi;
          x_pair  = e_pair;
          x_tag   = e_tag;
          wb_pend = 1'b1;
          mem_pend = 1'b0;
        end
      end else if (mem_pend) begin
        chk(1'b0, "R9 request missing", 64'd0, 64'd1);
      end
      // acceptance: build expectations from the requirements
      if (op_valid && op_ready) begin
        logic [63:0] old, nxt;
        string mt, kt;
        bit    stp, own;
        acc_cnt++;
        chk(rf_lo_idx == {op_pair, 1'b0} && rf_hi_idx == {op_pair, 1'b1} && rf_src_idx == op_reg,
            "R1 read indices", {49'd0, rf_hi_idx, rf_lo_idx, rf_src_idx}, {49'd0, op_pair, 1'b1, op_pair, 1'b0, op_reg});
        old = {rf[{op_pair, 1'b1}], rf[{op_pair, 1'b0}]};
        nxt = old + {{56{op_step[7]}}, op_step};
        stp = (op_mode == 2'd1) || (op_mode == 2'd2);
        mt  = (op_mode == 2'd1) ? "R3" : (op_mode == 2'd2) ? "R4" : "R2";
        kt  = (op_kind == 3'd0) ? "R6" : (op_kind <= 3'd3) ? "R7" : (op_kind <= 3'd5) ? "R8" : "R11";
        own = (op_kind == 3'd0) && (op_reg[4:1] == op_pair);
        if (op_kind <= 3'd3) begin
          mem_pend = 1'b1;
          e_addr = (op_mode == 2'd2) ? nxt[31:0] : old[31:0];
          e_we   = (op_kind != 3'd0);
          e_ld   = (op_kind == 3'd0);
          e_rd   = op_reg;
          e_wdata = (op_kind == 3'd1) ? rf[op_reg] :
                    (op_kind == 3'd2) ? {{20{op_imm[11]}}, op_imm[11:0]} : op_imm;
          e_loen = stp && !(own && !op_reg[0]);
          e_hien = stp && !(own && op_reg[0]);
          e_lo   = nxt[31:0];
          e_hi   = nxt[63:32];
          e_pair = op_pair;
          e_tag  = {kt, " ", mt};
        end else if (op_kind <= 3'd5) begin
          wb_pend = 1'b1;
          x_rden  = 1'b1;
          x_rdidx = op_reg;
          x_rddata = (op_kind == 3'd4) ? {{20{op_imm[11]}}, op_imm[11:0]} : op_imm;
          x_loen  = 1'b0;
          x_hien  = 1'b0;
          x_tag   = kt;
        end
      end
    end
  end

  // memory responder with programmable wait cycles
  initial begin
    int cnt;
    cnt = 0;
    mem_ready = 1'b0;
    mem_rdata = 32'd0;
    forever begin
      @(posedge clk);
      #1;
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_valid) begin
        if (cnt >= lat) begin
          mem_ready = 1'b1;
          mem_rdata = mread(mem_addr);
          cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic issue(input logic [2:0] k, input logic [3:0] p, input logic [4:0] r,
                       input logic [7:0] q, input logic [1:0] m, input logic [31:0] im);
    int a0;
    @(posedge clk);
    #1;
    op_kind = k; op_pair = p; op_reg = r; op_step = q; op_mode = m; op_imm = im;
    a0 = acc_cnt;
    op_valid = 1'b1;
    @(posedge clk);
    while (acc_cnt == a0) @(posedge clk);
    #1 op_valid = 1'b0;
    @(posedge clk);
    while (mem_pend || wb_pend) @(posedge clk);
  endtask

  task automatic setpair(input logic [3:0] p, input logic [31:0] hi, input logic [31:0] lo);
    issue(3'd5, p, {p, 1'b1}, 8'd0, 2'd0, hi);
    issue(3'd5, p, {p, 1'b0}, 8'd0, 2'd0, lo);
  endtask

  task automatic run_all();
    rst_n = 1'b0;
    op_valid = 1'b0; op_kind = 3'd0; op_pair = 4'd0; op_reg = 5'd0;
    op_step = 8'd0; op_mode = 2'd0; op_imm = 32'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R2 R6: plain load, pair untouched
    setpair(4'd0, 32'h0, 32'h0000_1000);
    issue(3'd0, 4'd0, 5'd6, 8'd4, 2'd0, 32'd0);
    // R3 R7: post-step store of a register
    issue(3'd1, 4'd0, 5'd6, 8'd8, 2'd1, 32'd0);
    // R4 R7: pre-step with negative step, short immediate sign-extended
    issue(3'd2, 4'd0, 5'd0, 8'hFC, 2'd2, 32'h0000_0FFF);
    issue(3'd0, 4'd0, 5'd9, 8'd0, 2'd0, 32'd0);
    // R5 R1: carry into upper half on the last pair
    setpair(4'd15, 32'h1, 32'hFFFF_FFFF);
    issue(3'd3, 4'd15, 5'd0, 8'd1, 2'd2, 32'hCAFE_F00D);
    // R5: full 64-bit wrap, and borrow across halves
    setpair(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(3'd0, 4'd7, 5'd2, 8'd1, 2'd1, 32'd0);
    setpair(4'd3, 32'h5, 32'h0);
    issue(3'd1, 4'd3, 5'd9, 8'hFF, 2'd1, 32'd0);
    // R10: load into own pair halves, with stalls (R9)
    lat = 2;
    setpair(4'd2, 32'h0, 32'h0000_2000);
    issue(3'd0, 4'd2, 5'd4, 8'd4, 2'd1, 32'd0);
    setpair(4'd2, 32'h0, 32'h0000_2000);
    issue(3'd0, 4'd2, 5'd5, 8'hF8, 2'd2, 32'd0);
    // R8: immediate loads
    lat = 0;
    issue(3'd4, 4'd0, 5'd10, 8'd0, 2'd0, 32'h0000_0800);
    issue(3'd4, 4'd0, 5'd12, 8'd0, 2'd0, 32'hFFFF_F7FF);
    issue(3'd5, 4'd0, 5'd11, 8'd0, 2'd0, 32'h1234_5678);
    // R11: reserved kinds; R2: mode 3 behaves as plain
    issue(3'd6, 4'd1, 5'd3, 8'd5, 2'd1, 32'd0);
    issue(3'd7, 4'd1, 5'd3, 8'd5, 2'd2, 32'd0);
    issue(3'd1, 4'd1, 5'd3, 8'd5, 2'd3, 32'd0);
    // R9: long stalls on stores and loads
    lat = 3;
    issue(3'd3, 4'd4, 5'd0, 8'd16, 2'd1, 32'hA5A5_0001);
    issue(3'd0, 4'd4, 5'd20, 8'hF0, 2'd2, 32'd0);
    // random mix, biased toward own-pair loads
    for (int i = 0; i < 120; i++) begin
      logic [3:0] p;
      logic [4:0] r;
      p = 4'($urandom_range(0, 15));
      r = ($urandom_range(0, 3) == 0) ? {p, 1'($urandom_range(0, 1))} : 5'($urandom_range(0, 31));
      lat = $urandom_range(0, 3);
      issue(3'($urandom_range(0, 7)), p, r, 8'($urandom), 2'($urandom_range(0, 3)), $urandom);
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        #2_000_000;
        wd = 1'b1;
      end
    join_any
    if (wd) $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + int'(wd), n_fail + int'(wd));
    $finish;
  end

endmodule